// File: doc/BRIEF.md
# Motor Driver Protection Supervisor

This block watches the protection comparators around an H-bridge stepping-motor power stage and decides when the bridge must be forced off. It receives single-bit flags from analog comparators outside the block. Temperature has two flags: a trip flag and a release flag that sits 40 degrees lower, which gives the hysteresis. Over-current has one flag covering every switch. The supply has three flags: below the lower under-voltage threshold, above the upper under-voltage threshold, and too low for the thermal and current detectors to be trusted. The block also receives the latch or auto-return select, the enable pin, the standby indication, and a one-cycle strobe that marks the start of each PWM period, which is also the start of a charge phase.

The block produces three outputs. The first is a force-off command for the bridge pre-drivers. The second is an active-low alert request for an open-drain pad, pulled while a thermal or over-current shutdown holds. The third is a force-initial request that makes the step sequencer return to its initial position. That request stays high while an under-voltage lockout is active and through the lockout that follows reset.

Recovery depends on the return policy. In latch policy, a thermal or current shutdown ends only after an enable high-low-high sequence or a reset. In auto policy, both thermal and current shutdowns resume at a PWM period start, between one and two periods after the condition clears. Under-voltage always recovers by itself once both supplies are good.

Top module: `drv_fault_supervisor`

## Requirements
- R1: While reset is high, and after it until the supply-good flag is seen, force_off=1, force_init=1 and alert_n=1.
- R2: A sampled supply-low flag sets the under-voltage lockout at the next edge (force_off=1, force_init=1, alert_n stays 1). The lockout clears only on an edge where supply-high=1 and supply-low=0.
- R3: A temperature-trip flag sampled high while protection is usable sets force_off=1 and alert_n=0 after that edge.
- R4: With auto_ret=1 or standby=1, a thermal shutdown whose release flag is high and trip flag low resumes (force_off=0, alert_n=1) on the RETRY_PERIODS-th PWM strobe sampled after the release was first seen. The default is 2. A release flag that drops before then re-arms the shutdown.
- R5: With auto_ret=0 and standby=0, a thermal shutdown holds through release and any number of strobes, until an enable high-low-high sequence.
- R6: An over-current flag trips only after it has been high for MASK_CYC consecutive samples. It then sets force_off=1 and alert_n=0 at the edge of the MASK_CYC-th sample. Any shorter pulse has no effect.
- R7: With auto_ret=1, an over-current shutdown resumes on the RETRY_PERIODS-th PWM strobe sampled after the trip.
- R8: With auto_ret=0, an over-current shutdown holds through strobes until an enable high-low-high sequence.
- R9: While standby=1, over-current detection is disabled.
- R10: While the no-protection supply flag is high, neither temperature trip nor over-current can start a shutdown.
- R11: An enable rising edge clears a latched shutdown only if enable was high at some earlier sampled edge and was low for at least one sampled cycle just before the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| temp_trip | input | 1 | Temperature above trip threshold |
| temp_cool | input | 1 | Temperature below return threshold |
| ovc_any | input | 1 | Over-current seen on any bridge switch |
| sup_low | input | 1 | Either supply below lower lockout threshold |
| sup_high | input | 1 | Both supplies above upper lockout threshold |
| sup_noprot | input | 1 | Supply too low for thermal/current detection |
| auto_ret | input | 1 | 1 = automatic return, 0 = latch until enable cycle |
| en | input | 1 | Enable pin level |
| stby | input | 1 | Standby active |
| pwm_strobe | input | 1 | One-cycle pulse at each PWM period (charge) start |
| force_off | output | 1 | 1 = all bridge switches off |
| alert_n | output | 1 | 0 = pull the alert pad low (thermal or current shutdown) |
| force_init | output | 1 | 1 = sequencer to initial step position |

## Verification
The bench targets the edges of the recovery windows. It counts exactly MASK_CYC versus MASK_CYC-1 over-current samples, because a filter off by one would trip on a noise spike or miss a genuine fault. It counts strobes after a thermal release or current trip, because a design that resumed on the first strobe would cut the off time below one period. It checks that latch policy survives any number of strobes and that standby turns a thermal latch into auto-return. It also checks that the very first enable rise after reset does not count as a high-low-high sequence, and that the alert stays released during an under-voltage lockout that has no thermal or current cause.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [1:0] {
        TH_RUN  = 2'd0,
        TH_HOT  = 2'd1,
        TH_COOL = 2'd2
    } therm_state_e;

    typedef struct packed {
        logic therm_ok;
        logic ovc_ok;
    } det_gate_t;

    function automatic det_gate_t gate_detectors(input logic noprot, input logic standby);
        det_gate_t g;
        g.therm_ok = !noprot;
        g.ovc_ok   = !noprot && !standby;
        return g;
    endfunction

endpackage

// File: rtl/fsup_en_tracker.sv
module fsup_en_tracker (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic clr_pulse
);
    logic en_q;
    logic seen_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            seen_hi <= 1'b0;
        end else begin
            en_q <= en;
            if (en_q) begin
                seen_hi <= 1'b1;
            end
        end
    end

    // rising edge counts only when a high level was seen before the low one
    assign clr_pulse = en && !en_q && seen_hi;
endmodule

// File: rtl/fsup_therm.sv
module fsup_therm
    import fsup_pkg::*;
#(
    parameter int RETRY_PERIODS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic det_ok,
    input  logic temp_trip,
    input  logic temp_cool,
    input  logic auto_eff,
    input  logic strobe,
    input  logic clr,
    output logic therm_off
);
    localparam int RW = $clog2(RETRY_PERIODS + 1);
    localparam logic [RW-1:0] R_LAST = RW'(RETRY_PERIODS - 1);

    therm_state_e st;
    logic [RW-1:0] per_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= TH_RUN;
            per_cnt <= '0;
        end else begin
            case (st)
                TH_HOT: begin
                    if (clr) begin
                        st <= TH_RUN;
                    end else if (auto_eff && temp_cool && !temp_trip) begin
                        st      <= TH_COOL;
                        per_cnt <= '0;
                    end
                end
                TH_COOL: begin
                    if (clr) begin
                        st <= TH_RUN;
                    end else if (!temp_cool || temp_trip) begin
                        st <= TH_HOT;
                    end else if (strobe) begin
                        if (per_cnt == R_LAST) begin
                            st <= TH_RUN;
                        end else begin
                            per_cnt <= per_cnt + 1'b1;
                        end
                    end
                end
                default: st <= TH_RUN;
            endcase
            if (det_ok && temp_trip) begin
                st <= TH_HOT;
            end
        end
    end

    assign therm_off = (st != TH_RUN);

    assert_therm_trip_R3: assert property (@(posedge clk) disable iff (rst)
        (det_ok && temp_trip) |=> therm_off);

    assert_therm_resume_at_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(therm_off) |-> ($past(strobe) || $past(clr)));

    assert_therm_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (st == TH_HOT && !auto_eff && !clr) |=> therm_off);
endmodule

// File: rtl/fsup_ovc.sv
module fsup_ovc #(
    parameter int MASK_CYC      = 800,
    parameter int RETRY_PERIODS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic det_ok,
    input  logic ovc_any,
    input  logic auto_ret,
    input  logic strobe,
    input  logic clr,
    output logic ovc_off
);
    localparam int MW = $clog2(MASK_CYC + 1);
    localparam int RW = $clog2(RETRY_PERIODS + 1);
    localparam logic [MW-1:0] M_LAST = MW'(MASK_CYC - 1);
    localparam logic [RW-1:0] R_LAST = RW'(RETRY_PERIODS - 1);

    logic [MW-1:0] mask_cnt;
    logic [RW-1:0] per_cnt;
    logic          hit;

    assign hit = det_ok && ovc_any && (mask_cnt == M_LAST);

    always_ff @(posedge clk) begin
        if (rst || !det_ok || !ovc_any) begin
            mask_cnt <= '0;
        end else if (mask_cnt != M_LAST) begin
            mask_cnt <= mask_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovc_off <= 1'b0;
            per_cnt <= '0;
        end else if (hit) begin
            ovc_off <= 1'b1;
            per_cnt <= '0;
        end else if (ovc_off) begin
            if (clr) begin
                ovc_off <= 1'b0;
            end else if (auto_ret && strobe) begin
                if (per_cnt == R_LAST) begin
                    ovc_off <= 1'b0;
                end else begin
                    per_cnt <= per_cnt + 1'b1;
                end
            end
        end
    end

    assert_ovc_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovc_off) |-> ($past(ovc_any) && $past(det_ok)));

    assert_ovc_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ovc_off && !auto_ret && !clr) |=> ovc_off);

    assert_ovc_resume_at_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ovc_off) |-> ($past(strobe) || $past(clr)));
endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor
    import fsup_pkg::*;
#(
    parameter int MASK_CYC      = 800,
    parameter int RETRY_PERIODS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic temp_trip,
    input  logic temp_cool,
    input  logic ovc_any,
    input  logic sup_low,
    input  logic sup_high,
    input  logic sup_noprot,
    input  logic auto_ret,
    input  logic en,
    input  logic stby,
    input  logic pwm_strobe,
    output logic force_off,
    output logic alert_n,
    output logic force_init
);
    det_gate_t gate;
    logic      clr;
    logic      therm_off;
    logic      ovc_off;
    logic      uv_lock;

    assign gate = gate_detectors(sup_noprot, stby);

    fsup_en_tracker u_en (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .clr_pulse (clr)
    );

    fsup_therm #(.RETRY_PERIODS(RETRY_PERIODS)) u_therm (
        .clk       (clk),
        .rst       (rst),
        .det_ok    (gate.therm_ok),
        .temp_trip (temp_trip),
        .temp_cool (temp_cool),
        .auto_eff  (auto_ret || stby),
        .strobe    (pwm_strobe),
        .clr       (clr),
        .therm_off (therm_off)
    );

    fsup_ovc #(.MASK_CYC(MASK_CYC), .RETRY_PERIODS(RETRY_PERIODS)) u_ovc (
        .clk      (clk),
        .rst      (rst),
        .det_ok   (gate.ovc_ok),
        .ovc_any  (ovc_any),
        .auto_ret (auto_ret),
        .strobe   (pwm_strobe),
        .clr      (clr),
        .ovc_off  (ovc_off)
    );

    // under-voltage lockout: starts locked, releases only on the upper threshold
    always_ff @(posedge clk) begin
        if (rst || sup_low) begin
            uv_lock <= 1'b1;
        end else if (sup_high) begin
            uv_lock <= 1'b0;
        end
    end

    assign force_off  = uv_lock || therm_off || ovc_off;
    assign alert_n    = !(therm_off || ovc_off);
    assign force_init = uv_lock;

    assert_uv_release_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(force_init) |-> ($past(sup_high) && !$past(sup_low)));

    assert_uv_entry_R2: assert property (@(posedge clk) disable iff (rst)
        sup_low |=> (force_init && force_off));
endmodule

// File: tb/test_drv_fault_supervisor.sv
module test_drv_fault_supervisor;
    localparam int MASK = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic temp_trip = 0, temp_cool = 0, ovc_any = 0;
    logic sup_low = 0, sup_high = 0, sup_noprot = 0;
    logic auto_ret = 1, en = 0, stby = 0, pwm_strobe = 0;
    logic force_off, alert_n, force_init;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    drv_fault_supervisor #(.MASK_CYC(MASK), .RETRY_PERIODS(2)) i_drv_fault_supervisor (
        .clk(clk), .rst(rst), .temp_trip(temp_trip), .temp_cool(temp_cool),
        .ovc_any(ovc_any), .sup_low(sup_low), .sup_high(sup_high),
        .sup_noprot(sup_noprot), .auto_ret(auto_ret), .en(en), .stby(stby),
        .pwm_strobe(pwm_strobe), .force_off(force_off), .alert_n(alert_n),
        .force_init(force_init)
    );

    // fields: slo shi trip cool auto stby strobe noprot | off alert_n init
    localparam logic [10:0] VECS [0:15] = '{
        11'b01001000_010,  // supply good, lockout released
        11'b01101000_100,  // thermal trip
        11'b01001000_100,  // trip gone, still hot
        11'b01011000_100,  // release seen
        11'b01011010_100,  // first strobe
        11'b01011000_100,
        11'b01011010_010,  // second strobe resumes
        11'b10011000_111,  // supply low
        11'b00011000_111,  // between thresholds
        11'b01011000_010,  // above upper threshold
        11'b01101001_010,  // trip ignored, no protection
        11'b01001000_010,
        11'b01100100_100,  // trip in standby, latch policy
        11'b01010100_100,
        11'b01010110_100,
        11'b01010110_010   // standby forces auto return
    };

    function automatic string tag_of(input int i);
        if (i == 0) return "R1";
        if (i <= 6) return "R3/R4";
        if (i <= 9) return "R2";
        if (i <= 11) return "R10";
        return "R4_standby";
    endfunction

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act{off,alert_n,init}=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic strobe_once();
        pwm_strobe = 1;
        step();
        pwm_strobe = 0;
    endtask

    task automatic en_cycle();
        en = 0;
        step();
        en = 1;
        step();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog act=timeout exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        chk("R1 in reset", {force_off, alert_n, force_init}, 3'b111);
        rst = 0;
        step();
        chk("R1 after reset", {force_off, alert_n, force_init}, 3'b111);

        for (int i = 0; i < 16; i++) begin
            {sup_low, sup_high, temp_trip, temp_cool, auto_ret, stby, pwm_strobe, sup_noprot} = VECS[i][10:3];
            step();
            chk(tag_of(i), {force_off, alert_n, force_init}, VECS[i][2:0]);
        end
        {temp_trip, pwm_strobe, sup_noprot} = 3'b000;

        // thermal latch policy, first enable rise must not clear
        stby = 0; auto_ret = 0; temp_cool = 0;
        temp_trip = 1; step(); temp_trip = 0;
        chk("R3 latch trip", {force_off, alert_n, force_init}, 3'b100);
        temp_cool = 1;
        idle(2); strobe_once(); idle(2); strobe_once(); strobe_once();
        chk("R5 holds through strobes", {force_off, alert_n, force_init}, 3'b100);
        en = 1; step();
        chk("R11 first rise ignored", {force_off, alert_n, force_init}, 3'b100);
        en = 0; step();
        chk("R5 enable low still off", {force_off, alert_n, force_init}, 3'b100);
        en = 1; step();
        chk("R11 high-low-high clears", {force_off, alert_n, force_init}, 3'b010);

        // over-current mask window, auto policy
        auto_ret = 1;
        ovc_any = 1; idle(MASK - 1); ovc_any = 0;
        chk("R6 short pulse ignored", {force_off, alert_n, force_init}, 3'b010);
        step();
        ovc_any = 1; idle(MASK - 1);
        chk("R6 one sample short", {force_off, alert_n, force_init}, 3'b010);
        step(); ovc_any = 0;
        chk("R6 trips at mask end", {force_off, alert_n, force_init}, 3'b100);
        idle(2); strobe_once();
        chk("R7 first strobe still off", {force_off, alert_n, force_init}, 3'b100);
        idle(3); strobe_once();
        chk("R7 second strobe resumes", {force_off, alert_n, force_init}, 3'b010);

        // over-current latch policy
        auto_ret = 0;
        ovc_any = 1; idle(MASK); ovc_any = 0;
        chk("R8 latch trip", {force_off, alert_n, force_init}, 3'b100);
        strobe_once(); strobe_once(); strobe_once();
        chk("R8 holds through strobes", {force_off, alert_n, force_init}, 3'b100);
        en_cycle();
        chk("R8 enable cycle clears", {force_off, alert_n, force_init}, 3'b010);

        // standby and no-protection gating
        auto_ret = 1; stby = 1;
        ovc_any = 1; idle(3 * MASK); ovc_any = 0; step();
        chk("R9 standby blocks over-current", {force_off, alert_n, force_init}, 3'b010);
        stby = 0; sup_noprot = 1;
        ovc_any = 1; idle(3 * MASK); ovc_any = 0; step();
        chk("R10 no-protection blocks over-current", {force_off, alert_n, force_init}, 3'b010);
        sup_noprot = 0;

        // thermal return re-arms if release drops before the period count ends
        temp_trip = 1; step(); temp_trip = 0; temp_cool = 1; step();
        strobe_once(); temp_cool = 0; step(); temp_cool = 1; step();
        strobe_once();
        chk("R4 re-armed count", {force_off, alert_n, force_init}, 3'b100);
        strobe_once();
        chk("R4 resume after re-arm", {force_off, alert_n, force_init}, 3'b010);

        rst = 1; step();
        chk("R1 reset mid-run", {force_off, alert_n, force_init}, 3'b111);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule